// File: doc/BRIEF.md
# Operand Addressing-Mode Address Generator

This block resolves one operand at a time for a 16-bit core with sixteen 16-bit registers. Register 0 serves as the program counter, register 1 as the stack pointer, register 2 as the status register and register 3 as the constant generator. The other twelve are general purpose. For each operand the issuing logic presents an addressing-mode code, a role (source or destination), a register index, a byte/word size flag, an extension word and a flat copy of the register file. The block answers with one of three results: a register selector, a memory effective address with a memory-access strobe, or an immediate value. A post-incrementing source also produces a register write-back request.

The issuing side and the consuming side each use a valid/ready handshake. An accepted operand is resolved in one clock and held until the consumer takes it. The write-back request is meant to be applied to the register file when the output handshake completes. A combinational output tells fetch logic whether the presented mode needs an extension word, so that word can be fetched before resolution.

Mode codes: 0 register, 1 indexed, 2 symbolic, 3 absolute, 4 indirect, 5 indirect with post-increment, 6 immediate, 7 reserved.

Top module: `opnd_agen`

## Requirements
- R1: After reset, outValid is 0, inReady is 1, and wbEn, memAccess and illegalMode are 0.
- R2: An operand accepted on a clock edge where inValid and inReady are both 1 appears with outValid=1 after that edge. While outValid=1 and outReady=0, every output holds its value and inReady is 0.
- R3: Mode 0 in either role gives useReg=1 and regSel equal to the index. It gives memAccess=0, wbEn=0 and immFlag=0 in that same cycle.
- R4: Mode 1 in either role gives memAccess=1 and effAddr = (extWord + R[index]) mod 2^16.
- R5: Mode 2 in either role gives memAccess=1 and effAddr = (extWord + R0) mod 2^16.
- R6: Mode 3 in either role gives memAccess=1 and effAddr = extWord.
- R7: Source mode 4 gives memAccess=1, effAddr = R[index] and wbEn=0.
- R8: Source mode 5 gives memAccess=1, effAddr = R[index], wbEn=1 and wbIdx = index. wbData is R[index] plus 2 for a word operand, or plus 1 for a byte operand, modulo 2^16. When the index is 1, the step is always 2.
- R9: Source mode 6 gives immFlag=1 and immValue = extWord, with memAccess=0 and wbEn=0.
- R10: Destination modes 4 to 7 and source mode 7 give illegalMode=1, with memAccess, useReg, immFlag and wbEn all 0.
- R11: needExt is a combinational function of the presented inputs. It is 1 for modes 1, 2 and 3 in either role and for mode 6 as a source, and 0 otherwise.
- R12: misaligned is 1 exactly when memAccess=1, the operand is word-sized (byteOp=0) and bit 0 of effAddr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand request present |
| inReady | output | 1 | Request can be accepted |
| isDst | input | 1 | 1 = destination operand, 0 = source |
| mode | input | 3 | Addressing-mode code |
| regIdx | input | 4 | Register index |
| byteOp | input | 1 | 1 = byte operand, 0 = word |
| extWord | input | 16 | Extension word |
| regFile | input | 256 | Register contents, register n at bits [16n+15:16n] |
| needExt | output | 1 | Presented mode uses the extension word |
| outValid | output | 1 | Resolved operand present |
| outReady | input | 1 | Consumer takes the result |
| useReg | output | 1 | Operand is a register |
| regSel | output | 4 | Selected register |
| memAccess | output | 1 | Operand lives in memory |
| effAddr | output | 16 | Memory effective address |
| immFlag | output | 1 | Operand is an immediate |
| immValue | output | 16 | Immediate value |
| wbEn | output | 1 | Post-increment write-back request |
| wbIdx | output | 4 | Write-back register |
| wbData | output | 16 | Write-back value |
| illegalMode | output | 1 | Mode code not allowed for this role |
| misaligned | output | 1 | Word access at an odd address |

## Verification
A wrong decode shows up at the ports in the first cycle of outValid after the operand is accepted. It appears as the wrong result class, a missing or spurious write-back, or an address built from the wrong base. A slip in the adder or the step selection appears as a wrong effAddr or wbData in that same cycle. The bench therefore varies the register contents and the extension word in every sweep step, so that swapped operands or a wrong base cannot give the expected value by chance. A lost hold under backpressure shows as a changed output one cycle after the consumer stalls.

// File: rtl/opnd_agen_pkg.sv
package opnd_agen_pkg;

  typedef enum logic [2:0] {
    AM_REG = 3'd0,
    AM_IDX = 3'd1,
    AM_SYM = 3'd2,
    AM_ABS = 3'd3,
    AM_IND = 3'd4,
    AM_INC = 3'd5,
    AM_IMM = 3'd6,
    AM_RSV = 3'd7
  } addrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new result
    logic clear;    // drop result flags after handoff
    logic useReg;
    logic memAcc;
    logic addBase;  // include a register in the address
    logic basePc;   // that register is the program counter
    logic addExt;   // include the extension word
    logic imm;
    logic postInc;
    logic illegal;
  } agenCtrl_t;

endpackage

// File: rtl/opnd_agen_ctrl.sv
module opnd_agen_ctrl
  import opnd_agen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       isDst,
  input  logic [2:0] mode,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       needExt,
  output agenCtrl_t  ctrl
);

  logic accept;
  logic handoff;
  addrMode_e modeE;

  assign modeE   = addrMode_e'(mode);
  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;
  assign handoff = outValid && outReady;

  always_comb begin
    ctrl = '0;
    ctrl.load  = accept;
    ctrl.clear = handoff && !accept;
    unique case (modeE)
      AM_REG: ctrl.useReg = 1'b1;
      AM_IDX: begin
        ctrl.memAcc  = 1'b1;
        ctrl.addBase = 1'b1;
        ctrl.addExt  = 1'b1;
      end
      AM_SYM: begin
        ctrl.memAcc  = 1'b1;
        ctrl.addBase = 1'b1;
        ctrl.basePc  = 1'b1;
        ctrl.addExt  = 1'b1;
      end
      AM_ABS: begin
        ctrl.memAcc = 1'b1;
        ctrl.addExt = 1'b1;
      end
      AM_IND: begin
        if (isDst) ctrl.illegal = 1'b1;
        else begin
          ctrl.memAcc  = 1'b1;
          ctrl.addBase = 1'b1;
        end
      end
      AM_INC: begin
        if (isDst) ctrl.illegal = 1'b1;
        else begin
          ctrl.memAcc  = 1'b1;
          ctrl.addBase = 1'b1;
          ctrl.postInc = 1'b1;
        end
      end
      AM_IMM: begin
        if (isDst) ctrl.illegal = 1'b1;
        else ctrl.imm = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

  assign needExt = ctrl.addExt || ctrl.imm;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else if (accept) outValid <= 1'b1;
    else if (handoff) outValid <= 1'b0;
  end

endmodule

// File: rtl/opnd_agen_dp.sv
module opnd_agen_dp
  import opnd_agen_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG),
  parameter int SP_IDX = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  agenCtrl_t              ctrl,
  input  logic [IDX_W-1:0]       regIdx,
  input  logic                   byteOp,
  input  logic [DATA_W-1:0]      extWord,
  input  logic [NREG*DATA_W-1:0] regFile,
  output logic                   useReg,
  output logic [IDX_W-1:0]       regSel,
  output logic                   memAccess,
  output logic [DATA_W-1:0]      effAddr,
  output logic                   immFlag,
  output logic [DATA_W-1:0]      immValue,
  output logic                   wbEn,
  output logic [IDX_W-1:0]       wbIdx,
  output logic [DATA_W-1:0]      wbData,
  output logic                   illegalMode,
  output logic                   misaligned
);

  localparam int WORD_STEP = DATA_W / 8;
  localparam logic [IDX_W-1:0] SP_SEL = IDX_W'(SP_IDX);

  logic [DATA_W-1:0] regVal, pcVal, baseVal, addrNext, stepVal, incNext;

  assign regVal  = regFile[regIdx*DATA_W +: DATA_W];
  assign pcVal   = regFile[DATA_W-1:0];
  assign baseVal = ctrl.addBase ? (ctrl.basePc ? pcVal : regVal) : '0;
  assign addrNext = baseVal + (ctrl.addExt ? extWord : '0);
  assign stepVal = (byteOp && regIdx != SP_SEL) ? DATA_W'(1) : DATA_W'(WORD_STEP);
  assign incNext = regVal + stepVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      useReg      <= 1'b0;
      regSel      <= '0;
      memAccess   <= 1'b0;
      effAddr     <= '0;
      immFlag     <= 1'b0;
      immValue    <= '0;
      wbEn        <= 1'b0;
      wbIdx       <= '0;
      wbData      <= '0;
      illegalMode <= 1'b0;
      misaligned  <= 1'b0;
    end else if (ctrl.load) begin
      useReg      <= ctrl.useReg;
      regSel      <= ctrl.useReg ? regIdx : '0;
      memAccess   <= ctrl.memAcc;
      effAddr     <= ctrl.memAcc ? addrNext : '0;
      immFlag     <= ctrl.imm;
      immValue    <= ctrl.imm ? extWord : '0;
      wbEn        <= ctrl.postInc;
      wbIdx       <= ctrl.postInc ? regIdx : '0;
      wbData      <= ctrl.postInc ? incNext : '0;
      illegalMode <= ctrl.illegal;
      misaligned  <= ctrl.memAcc && !byteOp && addrNext[0];
    end else if (ctrl.clear) begin
      useReg      <= 1'b0;
      memAccess   <= 1'b0;
      immFlag     <= 1'b0;
      wbEn        <= 1'b0;
      illegalMode <= 1'b0;
      misaligned  <= 1'b0;
    end
  end

endmodule

// File: rtl/opnd_agen.sv
module opnd_agen
  import opnd_agen_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG),
  parameter int SP_IDX = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic                   isDst,
  input  logic [2:0]             mode,
  input  logic [IDX_W-1:0]       regIdx,
  input  logic                   byteOp,
  input  logic [DATA_W-1:0]      extWord,
  input  logic [NREG*DATA_W-1:0] regFile,
  output logic                   needExt,
  output logic                   outValid,
  input  logic                   outReady,
  output logic                   useReg,
  output logic [IDX_W-1:0]       regSel,
  output logic                   memAccess,
  output logic [DATA_W-1:0]      effAddr,
  output logic                   immFlag,
  output logic [DATA_W-1:0]      immValue,
  output logic                   wbEn,
  output logic [IDX_W-1:0]       wbIdx,
  output logic [DATA_W-1:0]      wbData,
  output logic                   illegalMode,
  output logic                   misaligned
);

  agenCtrl_t ctrl;

  opnd_agen_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .isDst    (isDst),
    .mode     (mode),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .needExt  (needExt),
    .ctrl     (ctrl)
  );

  opnd_agen_dp #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .IDX_W  (IDX_W),
    .SP_IDX (SP_IDX)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .regIdx      (regIdx),
    .byteOp      (byteOp),
    .extWord     (extWord),
    .regFile     (regFile),
    .useReg      (useReg),
    .regSel      (regSel),
    .memAccess   (memAccess),
    .effAddr     (effAddr),
    .immFlag     (immFlag),
    .immValue    (immValue),
    .wbEn        (wbEn),
    .wbIdx       (wbIdx),
    .wbData      (wbData),
    .illegalMode (illegalMode),
    .misaligned  (misaligned)
  );

endmodule

// File: rtl/opnd_agen_chk.sv
module opnd_agen_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic              useReg,
  input logic              memAccess,
  input logic [DATA_W-1:0] effAddr,
  input logic              immFlag,
  input logic              wbEn,
  input logic [IDX_W-1:0]  wbIdx,
  input logic [DATA_W-1:0] wbData,
  input logic              illegalMode,
  input logic              misaligned
);

  // R2
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(effAddr) && $stable(wbData)
      && $stable(wbIdx) && $stable(memAccess) && $stable(wbEn));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |-> !memAccess && !useReg && !immFlag && !wbEn);

  // R12
  misalign_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> memAccess && effAddr[0]);

  // R8
  wb_with_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> outValid && memAccess);

  // R3
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({useReg, memAccess, immFlag, illegalMode}));

endmodule

bind opnd_agen opnd_agen_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inReady     (inReady),
  .outValid    (outValid),
  .outReady    (outReady),
  .useReg      (useReg),
  .memAccess   (memAccess),
  .effAddr     (effAddr),
  .immFlag     (immFlag),
  .wbEn        (wbEn),
  .wbIdx       (wbIdx),
  .wbData      (wbData),
  .illegalMode (illegalMode),
  .misaligned  (misaligned)
);

// File: tb/opnd_agen_bench.sv
module opnd_agen_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic isDst = 1'b0;
  logic [2:0] mode = '0;
  logic [3:0] regIdx = '0;
  logic byteOp = 1'b0;
  logic [15:0] extWord = '0;
  logic [255:0] regFile = '0;
  logic outReady = 1'b1;
  logic inReady, needExt, outValid, useReg, memAccess, immFlag, wbEn;
  logic illegalMode, misaligned;
  logic [3:0] regSel, wbIdx;
  logic [15:0] effAddr, immValue, wbData;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  opnd_agen u_opnd_agen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .isDst(isDst), .mode(mode), .regIdx(regIdx), .byteOp(byteOp),
    .extWord(extWord), .regFile(regFile), .needExt(needExt),
    .outValid(outValid), .outReady(outReady), .useReg(useReg),
    .regSel(regSel), .memAccess(memAccess), .effAddr(effAddr),
    .immFlag(immFlag), .immValue(immValue), .wbEn(wbEn), .wbIdx(wbIdx),
    .wbData(wbData), .illegalMode(illegalMode), .misaligned(misaligned)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] regOf(input int n);
    return regFile[n*16 +: 16];
  endfunction

  task automatic fillRegs(input int seed);
    for (int n = 0; n < 16; n++)
      regFile[n*16 +: 16] = 16'((n * 16'h1357) ^ (seed * 16'h0F1D) ^ (seed << 3));
  endtask

  // present one operand, check the combinational extension flag, then the result
  task automatic runOp(input bit dst, input int m, input int idx, input bit bt,
                       input logic [15:0] ext);
    logic [15:0] rv, expAddr, expWb, step;
    bit expIll, expMem, expReg, expImm, expWbEn, expNeed;
    @(negedge clk);
    isDst = dst; mode = 3'(m); regIdx = 4'(idx); byteOp = bt; extWord = ext;
    inValid = 1'b1; outReady = 1'b1;
    #1;
    rv = regOf(idx);
    expIll = (m == 7) || (dst && m >= 4);
    expReg = (m == 0);
    expImm = (m == 6) && !dst;
    expMem = !expIll && (m >= 1 && m <= 5);
    expWbEn = (m == 5) && !dst;
    expNeed = (m >= 1 && m <= 3) || expImm;
    expAddr = 16'h0;
    if (m == 1) expAddr = ext + rv;
    if (m == 2) expAddr = ext + regOf(0);
    if (m == 3) expAddr = ext;
    if ((m == 4 || m == 5) && !dst) expAddr = rv;
    step = (bt && idx != 1) ? 16'd1 : 16'd2;
    expWb = rv + step;
    // R11
    chk(needExt == expNeed, "R11 needExt", 32'(needExt), 32'(expNeed));
    @(negedge clk);
    inValid = 1'b0;
    // R2
    chk(outValid == 1'b1, "R2 outValid", 32'(outValid), 1);
    // R10
    chk(illegalMode == expIll, "R10 illegal", 32'(illegalMode), 32'(expIll));
    // R3
    chk(useReg == expReg, "R3 useReg", 32'(useReg), 32'(expReg));
    if (expReg) chk(regSel == 4'(idx), "R3 regSel", 32'(regSel), 32'(idx));
    // R9
    chk(immFlag == expImm, "R9 immFlag", 32'(immFlag), 32'(expImm));
    if (expImm) chk(immValue == ext, "R9 immValue", 32'(immValue), 32'(ext));
    // R4 R5 R6 R7
    chk(memAccess == expMem, "R4-class memAccess", 32'(memAccess), 32'(expMem));
    if (expMem) begin
      if (m == 1) chk(effAddr == expAddr, "R4 effAddr", 32'(effAddr), 32'(expAddr));
      if (m == 2) chk(effAddr == expAddr, "R5 effAddr", 32'(effAddr), 32'(expAddr));
      if (m == 3) chk(effAddr == expAddr, "R6 effAddr", 32'(effAddr), 32'(expAddr));
      if (m == 4) chk(effAddr == expAddr, "R7 effAddr", 32'(effAddr), 32'(expAddr));
      if (m == 5) chk(effAddr == expAddr, "R8 effAddr", 32'(effAddr), 32'(expAddr));
      // R12
      chk(misaligned == (!bt && expAddr[0]), "R12 misaligned", 32'(misaligned),
          32'(!bt && expAddr[0]));
    end else begin
      chk(misaligned == 1'b0, "R12 misaligned", 32'(misaligned), 0);
    end
    // R8
    chk(wbEn == expWbEn, "R8 wbEn", 32'(wbEn), 32'(expWbEn));
    if (expWbEn) begin
      chk(wbIdx == 4'(idx), "R8 wbIdx", 32'(wbIdx), 32'(idx));
      chk(wbData == expWb, "R8 wbData", 32'(wbData), 32'(expWb));
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(outValid == 1'b0, "R1 outValid", 32'(outValid), 0);
    chk(inReady == 1'b1, "R1 inReady", 32'(inReady), 1);
    chk(wbEn == 1'b0 && memAccess == 1'b0 && illegalMode == 1'b0, "R1 flags",
        32'({wbEn, memAccess, illegalMode}), 0);
    rstN = 1'b1;

    // full sweep: role x mode x register x size, contents varied per step
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 8; m++)
        for (int r = 0; r < 16; r++)
          for (int b = 0; b < 2; b++) begin
            fillRegs(d * 256 + m * 32 + r * 2 + b + 1);
            runOp(d[0], m, r, b[0], 16'((m * 16'h2B1) ^ (r * 16'h91) ^ (b * 16'h4001)));
          end

    // wrap-around corners
    regFile[5*16 +: 16] = 16'hFFFF;
    runOp(1'b0, 5, 5, 1'b0, 16'h0);   // R8 wraps to 1
    runOp(1'b0, 5, 5, 1'b1, 16'h0);   // R8 wraps to 0
    regFile[1*16 +: 16] = 16'hFFFE;
    runOp(1'b0, 5, 1, 1'b1, 16'h0);   // R8 stack pointer steps by 2 even for bytes
    runOp(1'b1, 1, 5, 1'b0, 16'h0003); // R4 wraps to 2
    regFile[15:0] = 16'hFFF0;
    runOp(1'b1, 2, 9, 1'b0, 16'h0021); // R5 wraps to 0x11, odd word -> R12

    // backpressure: hold A while B waits
    fillRegs(77);
    @(negedge clk);
    isDst = 1'b0; mode = 3'd1; regIdx = 4'd4; byteOp = 1'b0; extWord = 16'h0100;
    inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    isDst = 1'b0; mode = 3'd3; regIdx = 4'd2; extWord = 16'h2222;
    // R2
    chk(inReady == 1'b0, "R2 inReady stall", 32'(inReady), 0);
    chk(effAddr == 16'(16'h0100 + regOf(4)), "R2 hold A", 32'(effAddr),
        32'(16'h0100 + regOf(4)));
    @(negedge clk);
    chk(outValid == 1'b1 && effAddr == 16'(16'h0100 + regOf(4)), "R2 hold A later",
        32'(effAddr), 32'(16'h0100 + regOf(4)));
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1 && effAddr == 16'h2222, "R2 B after release", 32'(effAddr),
        32'h2222);
    @(negedge clk);
    chk(outValid == 1'b0 && memAccess == 1'b0, "R2 drained", 32'(outValid), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule